// File: doc/BRIEF.md
# NAND Flash Host Controller

This block sits between a processor's register bus and one raw 8-bit NAND flash device. Software programs a configuration word (enable, chip-enable level, strobe timing) and then writes command, address and data bytes into dedicated registers. Each such write is turned into a complete latch cycle on the flash pins. A command write frames the byte with the command-latch line, an address write with the address-latch line, and a data write with neither. A data-register read runs a read-enable cycle and returns the sampled byte.

Every data byte moving in either direction is also handed to an external ECC generator on a one-cycle byte stream. That generator's parity code can be read back through three byte-wide registers. The controller holds off new register accesses while a flash cycle is in flight and signals this on a busy output. All flash activity is gated by a single enable bit. While that bit is clear, the command and address registers still store their values but the pins stay quiet.

Top module: `nand_host_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, the configuration, command and address registers read zero. The flash pins are idle during reset: nand_cle_o=0, nand_ale_o=0, nand_nwe_o=1, nand_nre_o=1, nand_io_oe_o=0. reg_busy_o=0 and ecc_clr_o=1.
- R2: A configuration write (offset 0x00) stores wdata & 0x9FFF, so bits 13 and 14 read back as zero. If wdata bit 12 is set, ecc_clr_o is high for the single cycle after the write.
- R3: With enable (config bit 15) set, a write to the command register (offset 0x04) stores wdata[7:0]. It then runs a cycle in which nand_cle_o is high for its whole length, nand_ale_o stays low, and nand_io_o carries the byte with nand_io_oe_o high while nand_nwe_o pulses low.
- R4: With enable set, a write to the address register (offset 0x08) runs the same cycle with nand_ale_o high in place of nand_cle_o.
- R5: With enable set, a write to the data register (offset 0x0C) drives wdata[7:0] with a nand_nwe_o pulse while CLE and ALE stay low. In the cycle after reg_busy_o falls, ecc_valid_o is high and ecc_byte_o equals that byte.
- R6: With enable set, a read of the data register pulses nand_nre_o low without driving the I/O bus. It samples nand_io_i at the last cycle of the pulse and returns the byte with reg_rvalid_o. The same byte goes out on ecc_byte_o with ecc_valid_o in the cycle after busy falls.
- R7: With enable clear, command, address and data accesses leave every flash strobe idle, raise no busy and no ecc_valid_o, and data reads return zero. Command and address writes still update their registers.
- R8: nand_nce_o always equals configuration bit 11.
- R9: nand_wp_o follows wp_i while idle. During a generated cycle it holds the wp_i value sampled when the cycle started.
- R10: A read of the status register (offset 0x10) returns nand_rb_i in bit 0 and zero elsewhere.
- R11: Reads of offsets 0x14, 0x15 and 0x16 return ecc_code_i[7:0], [15:8] and [23:16] in the low byte.
- R12: A cycle has a setup phase of cfg[2:0]+1 clocks with the latch line and data valid. A strobe phase of cfg[6:4]+1 clocks has nand_nwe_o or nand_nre_o low. A hold phase of cfg[10:8]+1 clocks follows. reg_busy_o is high for exactly the sum of the three.
- R13: Reads of undefined offsets return zero and writes to them change nothing. Register strobes arriving while reg_busy_o is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_wr_i | input | 1 | Write strobe, one cycle |
| reg_rd_i | input | 1 | Read strobe, one cycle |
| reg_rdata_o | output | 32 | Read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data valid pulse |
| reg_busy_o | output | 1 | Flash cycle in progress, strobes ignored |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_nce_o | output | 1 | Chip enable level from configuration |
| nand_wp_o | output | 1 | Write-protect forwarded to flash |
| nand_nwe_o | output | 1 | Write enable, active low |
| nand_nre_o | output | 1 | Read enable, active low |
| nand_io_o | output | 8 | I/O bus output byte |
| nand_io_oe_o | output | 1 | I/O bus output enable |
| nand_io_i | input | 8 | I/O bus input byte |
| nand_rb_i | input | 1 | Ready/busy from flash |
| wp_i | input | 1 | Write-protect request |
| ecc_byte_o | output | 8 | Byte fed to the ECC generator |
| ecc_valid_o | output | 1 | ECC byte valid pulse |
| ecc_clr_o | output | 1 | ECC generator clear |
| ecc_code_i | input | 24 | Parity code from the ECC generator |

## Verification
The latch function is tried in three ways. Command, address and data writes use the same minimal timing, so that only the choice of latch line and ECC feed separates them. A read of the data register shows that the bus is never driven while the read strobe is low. A second, stretched timing word shows that each phase length comes from its own field and not from a shared count. The same accesses are then repeated with the enable bit clear, and issued while a slow cycle is running, to tell "stored but not sent" apart from "dropped".

// File: rtl/nand_host_pkg.sv
package nand_host_pkg;

  localparam int ADDR_W = 5;
  localparam int CFG_W  = 16;
  localparam int TIM_W  = 3;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 24;

  localparam logic [CFG_W-1:0] CFG_MASK = 16'h9FFF;
  localparam int CFG_EN   = 15;
  localparam int CFG_ECLR = 12;
  localparam int CFG_CE   = 11;
  localparam int CFG_SU_LSB = 0;
  localparam int CFG_ST_LSB = 4;
  localparam int CFG_HO_LSB = 8;

  localparam logic [ADDR_W-1:0] OFF_CFG  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_CMD  = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_ADR  = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_DAT  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_STA  = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_ECC0 = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_ECC1 = 5'h15;
  localparam logic [ADDR_W-1:0] OFF_ECC2 = 5'h16;

  typedef enum logic [1:0] {OP_CMD, OP_ADR, OP_WDAT, OP_RDAT} nand_op_e;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} nand_ph_e;

  typedef struct packed {
    logic [TIM_W-1:0] hold;
    logic [TIM_W-1:0] strobe;
    logic [TIM_W-1:0] setup;
  } nand_tim_t;

endpackage

// File: rtl/nand_reg_file.sv
module nand_reg_file
  import nand_host_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              busy_i,
  input  logic              rb_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              rd_done_i,
  input  logic [BYTE_W-1:0] rd_byte_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              start_o,
  output nand_op_e          op_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o,
  output logic              ecc_clr_o
);

  logic [CFG_W-1:0]  cfg_q;
  logic [BYTE_W-1:0] cmd_q, adr_q;
  logic [DW-1:0]     rdata_q;
  logic              rvalid_q, clr_q;
  logic              acc_wr, acc_rd, en, seq_rd;
  logic [DW-1:0]     rd_val;

  assign en     = cfg_q[CFG_EN];
  assign acc_wr = wr_i & ~busy_i;
  assign acc_rd = rd_i & ~wr_i & ~busy_i;
  assign seq_rd = acc_rd & en & (addr_i == OFF_DAT);

  always_comb begin
    rd_val = '0;
    case (addr_i)
      OFF_CFG:  rd_val[CFG_W-1:0]  = cfg_q;
      OFF_CMD:  rd_val[BYTE_W-1:0] = cmd_q;
      OFF_ADR:  rd_val[BYTE_W-1:0] = adr_q;
      OFF_STA:  rd_val[0]          = rb_i;
      OFF_ECC0: rd_val[BYTE_W-1:0] = code_i[7:0];
      OFF_ECC1: rd_val[BYTE_W-1:0] = code_i[15:8];
      OFF_ECC2: rd_val[BYTE_W-1:0] = code_i[23:16];
      default:  rd_val = '0;
    endcase
  end

  always_comb begin
    start_o = 1'b0;
    op_o    = OP_CMD;
    byte_o  = wdata_i[BYTE_W-1:0];
    if (en && acc_wr) begin
      case (addr_i)
        OFF_CMD: begin start_o = 1'b1; op_o = OP_CMD;  end
        OFF_ADR: begin start_o = 1'b1; op_o = OP_ADR;  end
        OFF_DAT: begin start_o = 1'b1; op_o = OP_WDAT; end
        default: ;
      endcase
    end else if (seq_rd) begin
      start_o = 1'b1;
      op_o    = OP_RDAT;
      byte_o  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      cmd_q    <= '0;
      adr_q    <= '0;
      clr_q    <= 1'b1;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      clr_q    <= 1'b0;
      rvalid_q <= 1'b0;
      if (acc_wr) begin
        case (addr_i)
          OFF_CFG: begin
            cfg_q <= wdata_i[CFG_W-1:0] & CFG_MASK;
            clr_q <= wdata_i[CFG_ECLR];
          end
          OFF_CMD: cmd_q <= wdata_i[BYTE_W-1:0];
          OFF_ADR: adr_q <= wdata_i[BYTE_W-1:0];
          default: ;
        endcase
      end
      if (rd_done_i) begin
        rvalid_q <= 1'b1;
        rdata_q  <= {{(DW-BYTE_W){1'b0}}, rd_byte_i};
      end else if (acc_rd && !seq_rd) begin
        rvalid_q <= 1'b1;
        rdata_q  <= rd_val;
      end
    end
  end

  assign cfg_o     = cfg_q;
  assign rdata_o   = rdata_q;
  assign rvalid_o  = rvalid_q;
  assign ecc_clr_o = clr_q;

  // R2
  cfg_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q[14:13] == 2'b00);

  // R13
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(cfg_q) && $stable(cmd_q) && $stable(adr_q)));

endmodule

// File: rtl/nand_pin_seq.sv
module nand_pin_seq
  import nand_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  nand_op_e          op_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  nand_tim_t         tim_i,
  input  logic              wp_i,
  input  logic [BYTE_W-1:0] io_i,
  output logic              busy_o,
  output logic              cle_o,
  output logic              ale_o,
  output logic              nwe_o,
  output logic              nre_o,
  output logic              wp_o,
  output logic [BYTE_W-1:0] io_o,
  output logic              io_oe_o,
  output logic              rd_done_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              ecc_valid_o
);

  nand_ph_e          ph_q;
  nand_op_e          op_q;
  logic [TIM_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] byte_q;
  logic              wp_q, done_q, ecc_q;
  logic              last;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      op_q   <= OP_CMD;
      cnt_q  <= '0;
      byte_q <= '0;
      wp_q   <= 1'b0;
      done_q <= 1'b0;
      ecc_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ecc_q  <= 1'b0;
      case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q   <= PH_SETUP;
          op_q   <= op_i;
          byte_q <= byte_i;
          wp_q   <= wp_i;
          cnt_q  <= tim_i.setup;
        end
        PH_SETUP: if (last) begin
          ph_q  <= PH_STROBE;
          cnt_q <= tim_i.strobe;
        end else cnt_q <= cnt_q - 1'b1;
        PH_STROBE: if (last) begin
          ph_q  <= PH_HOLD;
          cnt_q <= tim_i.hold;
          if (op_q == OP_RDAT) byte_q <= io_i;
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (last) begin
          ph_q   <= PH_IDLE;
          done_q <= (op_q == OP_RDAT);
          ecc_q  <= (op_q == OP_RDAT) || (op_q == OP_WDAT);
        end else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o      = (ph_q != PH_IDLE);
  assign cle_o       = busy_o && (op_q == OP_CMD);
  assign ale_o       = busy_o && (op_q == OP_ADR);
  assign io_oe_o     = busy_o && (op_q != OP_RDAT);
  assign io_o        = io_oe_o ? byte_q : '0;
  assign nwe_o       = !((ph_q == PH_STROBE) && (op_q != OP_RDAT));
  assign nre_o       = !((ph_q == PH_STROBE) && (op_q == OP_RDAT));
  assign wp_o        = busy_o ? wp_q : wp_i;
  assign rd_done_o   = done_q;
  assign byte_o      = byte_q;
  assign ecc_valid_o = ecc_q;

  // R3
  latch_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));

  // R3
  we_drives_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nwe_o |-> (io_oe_o && nre_o));

  // R6
  re_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nre_o |-> (!io_oe_o && !cle_o && !ale_o));

  // R9
  wp_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(wp_o));

  // R5
  ecc_after_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_valid_o |-> ($past(ph_q) == PH_HOLD));

endmodule

// File: rtl/nand_host_ctrl.sv
module nand_host_ctrl
  import nand_host_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              reg_rvalid_o,
  output logic              reg_busy_o,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_nce_o,
  output logic              nand_wp_o,
  output logic              nand_nwe_o,
  output logic              nand_nre_o,
  output logic [BYTE_W-1:0] nand_io_o,
  output logic              nand_io_oe_o,
  input  logic [BYTE_W-1:0] nand_io_i,
  input  logic              nand_rb_i,
  input  logic              wp_i,
  output logic [BYTE_W-1:0] ecc_byte_o,
  output logic              ecc_valid_o,
  output logic              ecc_clr_o,
  input  logic [CODE_W-1:0] ecc_code_i
);

  logic [CFG_W-1:0]  cfg;
  logic              start, busy, rd_done;
  nand_op_e          op;
  logic [BYTE_W-1:0] wr_byte, seq_byte;
  nand_tim_t         tim;

  assign tim.setup  = cfg[CFG_SU_LSB +: TIM_W];
  assign tim.strobe = cfg[CFG_ST_LSB +: TIM_W];
  assign tim.hold   = cfg[CFG_HO_LSB +: TIM_W];

  nand_reg_file #(.DW(DW)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .wr_i      (reg_wr_i),
    .rd_i      (reg_rd_i),
    .busy_i    (busy),
    .rb_i      (nand_rb_i),
    .code_i    (ecc_code_i),
    .rd_done_i (rd_done),
    .rd_byte_i (seq_byte),
    .cfg_o     (cfg),
    .start_o   (start),
    .op_o      (op),
    .byte_o    (wr_byte),
    .rdata_o   (reg_rdata_o),
    .rvalid_o  (reg_rvalid_o),
    .ecc_clr_o (ecc_clr_o)
  );

  nand_pin_seq i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .op_i        (op),
    .byte_i      (wr_byte),
    .tim_i       (tim),
    .wp_i        (wp_i),
    .io_i        (nand_io_i),
    .busy_o      (busy),
    .cle_o       (nand_cle_o),
    .ale_o       (nand_ale_o),
    .nwe_o       (nand_nwe_o),
    .nre_o       (nand_nre_o),
    .wp_o        (nand_wp_o),
    .io_o        (nand_io_o),
    .io_oe_o     (nand_io_oe_o),
    .rd_done_o   (rd_done),
    .byte_o      (seq_byte),
    .ecc_valid_o (ecc_valid_o)
  );

  assign reg_busy_o = busy;
  assign nand_nce_o = cfg[CFG_CE];
  assign ecc_byte_o = seq_byte;

  // R7
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg[CFG_EN] && !busy) |=> (nand_nwe_o && nand_nre_o && !nand_cle_o && !nand_ale_o && !reg_busy_o));

endmodule

// File: tb/test_nand_host_ctrl.sv
module test_nand_host_ctrl;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid, reg_busy;
  logic        cle, ale, nce, wpo, nwe, nre, io_oe;
  logic [7:0]  io_o;
  logic [7:0]  io_i = '0;
  logic        rb = 1'b0, wp = 1'b0;
  logic [7:0]  ecc_byte;
  logic        ecc_valid, ecc_clr;
  logic [23:0] ecc_code = '0;

  int checks = 0, errors = 0;
  int n_busy, n_we, n_re, n_cle, n_ale, n_oe, wp_bad;
  logic [7:0]  io_seen, ecc_b;
  logic        ecc_v, clr_seen, flip_wp;
  logic [31:0] rd_res;

  always #5 clk = ~clk;

  nand_host_ctrl i_nand_host_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_rdata_o(reg_rdata), .reg_rvalid_o(reg_rvalid),
    .reg_busy_o(reg_busy), .nand_cle_o(cle), .nand_ale_o(ale), .nand_nce_o(nce),
    .nand_wp_o(wpo), .nand_nwe_o(nwe), .nand_nre_o(nre), .nand_io_o(io_o),
    .nand_io_oe_o(io_oe), .nand_io_i(io_i), .nand_rb_i(rb), .wp_i(wp),
    .ecc_byte_o(ecc_byte), .ecc_valid_o(ecc_valid), .ecc_clr_o(ecc_clr),
    .ecc_code_i(ecc_code)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one register access; records pin activity until the flash cycle ends
  task automatic xfer(input logic is_wr, input logic [4:0] a, input logic [31:0] d);
    logic wp_ref;
    int guard;
    n_busy = 0; n_we = 0; n_re = 0; n_cle = 0; n_ale = 0; n_oe = 0; wp_bad = 0;
    io_seen = '0; rd_res = '0;
    wp_ref = wp;
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = is_wr; reg_rd = !is_wr;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    clr_seen = ecc_clr;
    guard = 0;
    while (reg_busy && guard < 200) begin
      n_busy++;
      if (!nwe) begin n_we++; io_seen = io_o; end
      if (!nre) n_re++;
      if (cle) n_cle++;
      if (ale) n_ale++;
      if (io_oe) n_oe++;
      if (wpo !== wp_ref) wp_bad++;
      if (guard == 0 && flip_wp) wp = ~wp;
      guard++;
      @(negedge clk);
    end
    ecc_v = ecc_valid; ecc_b = ecc_byte;
    if (!is_wr) begin
      guard = 0;
      while (!reg_rvalid && guard < 4) begin @(negedge clk); guard++; end
      rd_res = reg_rvalid ? reg_rdata : 32'hDEADBEEF;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "cle", cle, 0);     chk("R1", "ale", ale, 0);
    chk("R1", "nwe", nwe, 1);     chk("R1", "nre", nre, 1);
    chk("R1", "io_oe", io_oe, 0); chk("R1", "busy", reg_busy, 0);
    chk("R1", "ecc_clr", ecc_clr, 1);
    rst_ni = 1'b1;
    xfer(0, 5'h00, 0); chk("R1", "cfg", rd_res, 0);
    xfer(0, 5'h04, 0); chk("R1", "cmd", rd_res, 0);
    xfer(0, 5'h08, 0); chk("R1", "addr", rd_res, 0);
  endtask

  task automatic t_cfg_mask;
    xfer(1, 5'h00, 32'hFFFF); chk("R2", "clr pulse", clr_seen, 1);
    xfer(0, 5'h00, 0);        chk("R2", "mask", rd_res, 32'h9FFF);
    xfer(1, 5'h00, 32'h8000); chk("R2", "no clr", clr_seen, 0);
  endtask

  task automatic t_nce;
    xfer(1, 5'h00, 32'h8800); chk("R8", "nce high", nce, 1);
    xfer(1, 5'h00, 32'h8000); chk("R8", "nce low", nce, 0);
  endtask

  task automatic t_cmd;
    xfer(1, 5'h04, 32'h170);
    chk("R3", "busy", n_busy, 3); chk("R3", "we", n_we, 1);
    chk("R3", "cle", n_cle, 3);   chk("R3", "ale", n_ale, 0);
    chk("R3", "io", io_seen, 8'h70); chk("R3", "ecc", ecc_v, 0);
    xfer(0, 5'h04, 0); chk("R3", "cmd reg", rd_res, 32'h70);
  endtask

  task automatic t_addr;
    xfer(1, 5'h08, 32'hA5);
    chk("R4", "ale", n_ale, 3); chk("R4", "cle", n_cle, 0);
    chk("R4", "we", n_we, 1);   chk("R4", "io", io_seen, 8'hA5);
  endtask

  task automatic t_wdata;
    xfer(1, 5'h0C, 32'h3C);
    chk("R5", "we", n_we, 1); chk("R5", "latch", n_cle + n_ale, 0);
    chk("R5", "io", io_seen, 8'h3C);
    chk("R5", "ecc valid", ecc_v, 1); chk("R5", "ecc byte", ecc_b, 8'h3C);
  endtask

  task automatic t_rdata;
    io_i = 8'hC9;
    xfer(0, 5'h0C, 0);
    chk("R6", "re", n_re, 1); chk("R6", "we", n_we, 0); chk("R6", "oe", n_oe, 0);
    chk("R6", "rdata", rd_res, 32'hC9);
    chk("R6", "ecc valid", ecc_v, 1); chk("R6", "ecc byte", ecc_b, 8'hC9);
  endtask

  task automatic t_timing;
    xfer(1, 5'h00, 32'h8132);
    xfer(1, 5'h04, 32'h90);
    chk("R12", "busy", n_busy, 9); chk("R12", "we", n_we, 4); chk("R12", "cle", n_cle, 9);
    io_i = 8'h5A;
    xfer(0, 5'h0C, 0);
    chk("R12", "re", n_re, 4); chk("R12", "rd busy", n_busy, 9);
    chk("R12", "rdata", rd_res, 32'h5A);
    xfer(1, 5'h00, 32'h8000);
  endtask

  task automatic t_wp;
    wp = 1'b1; flip_wp = 1'b1;
    xfer(1, 5'h04, 32'h01);
    flip_wp = 1'b0;
    chk("R9", "held during cycle", wp_bad, 0);
    chk("R9", "follows when idle", wpo, wp);
  endtask

  task automatic t_disabled;
    xfer(1, 5'h00, 32'h0000);
    xfer(1, 5'h04, 32'h55);
    chk("R7", "cmd busy", n_busy, 0); chk("R7", "cmd cle", cle, 0);
    xfer(0, 5'h04, 0); chk("R7", "cmd stored", rd_res, 32'h55);
    xfer(1, 5'h0C, 32'h77);
    chk("R7", "dat busy", n_busy, 0); chk("R7", "dat ecc", ecc_v, 0);
    io_i = 8'hFF;
    xfer(0, 5'h0C, 0);
    chk("R7", "dat read", rd_res, 0); chk("R7", "re", n_re, 0);
  endtask

  task automatic t_status;
    rb = 1'b1; xfer(0, 5'h10, 0); chk("R10", "ready", rd_res, 1);
    rb = 1'b0; xfer(0, 5'h10, 0); chk("R10", "busy", rd_res, 0);
  endtask

  task automatic t_ecc;
    ecc_code = 24'hABCDEF;
    xfer(0, 5'h14, 0); chk("R11", "byte0", rd_res, 32'hEF);
    xfer(0, 5'h15, 0); chk("R11", "byte1", rd_res, 32'hCD);
    xfer(0, 5'h16, 0); chk("R11", "byte2", rd_res, 32'hAB);
  endtask

  task automatic t_undef;
    xfer(1, 5'h00, 32'h8000);
    xfer(1, 5'h18, 32'hFFFF); chk("R13", "undef busy", n_busy, 0);
    xfer(0, 5'h18, 0);        chk("R13", "undef 18", rd_res, 0);
    xfer(0, 5'h02, 0);        chk("R13", "undef 02", rd_res, 0);
    xfer(0, 5'h00, 0);        chk("R13", "cfg kept", rd_res, 32'h8000);
  endtask

  task automatic t_busy_ignore;
    int guard;
    xfer(1, 5'h00, 32'h8777);
    @(negedge clk); reg_addr = 5'h04; reg_wdata = 32'h11; reg_wr = 1'b1;
    @(negedge clk); reg_addr = 5'h00; reg_wdata = 32'h0;
    @(negedge clk); reg_addr = 5'h04; reg_wdata = 32'h22;
    @(negedge clk); reg_wr = 1'b0;
    guard = 0;
    while (reg_busy && guard < 100) begin @(negedge clk); guard++; end
    xfer(0, 5'h00, 0); chk("R13", "cfg while busy", rd_res, 32'h8777);
    xfer(0, 5'h04, 0); chk("R13", "cmd while busy", rd_res, 32'h11);
  endtask

  initial begin
    flip_wp = 1'b0;
    t_reset;
    t_cfg_mask;
    t_nce;
    t_cmd;
    t_addr;
    t_wdata;
    t_rdata;
    t_timing;
    t_wp;
    t_disabled;
    t_status;
    t_ecc;
    t_undef;
    t_busy_ignore;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

endmodule